// File: doc/BRIEF.md
# Sensor Node Power-State Sequencer

This block walks a battery-powered sensor node through a repeating work cycle: a short full-rate standby, a short sleep while the sensor collects samples, reading the sensor, encrypting the reading, sending it over the radio, and then a long sleep. In each state it tells a separate clock-enable unit which low-power mode to apply and, while sleeping, which sleep-length code the wake timer should load.

The acquisition, cipher and transmit engines are started by single-cycle pulses. Each engine answers with a done strobe. The wake timer answers with a wake strobe. A data-variability flag picks the length of the sleep after transmission. When readings barely change, there is little value in sending them often, so a flag that is high at the end of transmission selects a stretched sleep instead of the nominal one.

Top module: `sensor_pwr_seq`

## Requirements
- R1: A synchronous reset puts the node in standby, with state code 3'b001. While reset is applied the mode request is 2'd0, all start outputs are low and the sleep code is 0.
- R2: Standby lasts exactly STANDBY_CYCLES clock cycles. The node then enters sample-wait (3'b010).
- R3: In sample-wait the mode request is 2'd3 (clock halted) and the sleep code is SHORT_CODE. The state changes only on a wake strobe, which moves it to acquire (3'b011).
- R4: In acquire the mode request is 2'd1. The acquisition start pulses high for exactly the first cycle of the state. The state holds until acquisition-done and then moves to encrypt (3'b100).
- R5: In encrypt the mode request is 2'd0. The cipher start pulses high for exactly the first cycle of the state. The state holds until cipher-done and then moves to transmit (3'b101).
- R6: In transmit the mode request is 2'd2. The transmit start pulses high for exactly the first cycle of the state. The state holds until transmit-done and then moves to sleep (3'b000).
- R7: The sleep code during sleep is chosen from the variability flag as sampled in the cycle where transmit-done is accepted. A low flag gives NOMINAL_CODE and a high flag gives STRETCH_CODE. The code does not change for the rest of that sleep, whatever the flag does afterwards.
- R8: In sleep the mode request is 2'd3. A wake strobe returns the node to standby, and the standby length of R2 starts over.
- R9: A done or wake strobe that does not belong to the current state has no effect on state, mode or outputs.
- R10: The sleep code is 0 in every state other than sample-wait and sleep.
- R11: At most one engine start output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acq_done | input | 1 | Acquisition engine finished |
| enc_done | input | 1 | Cipher engine finished |
| tx_done | input | 1 | Transmit engine finished |
| wake | input | 1 | Sleep timer expired |
| low_var | input | 1 | Sensor data changed little; stretch the post-transmit sleep |
| mode_req | output | 2 | Low-power mode request to the clock-enable unit |
| sleep_code | output | CODE_W (8) | Sleep-length code for the wake timer |
| acq_start | output | 1 | Single-cycle start to the acquisition engine |
| enc_start | output | 1 | Single-cycle start to the cipher engine |
| tx_start | output | 1 | Single-cycle start to the transmit engine |
| state_out | output | 3 | Current state encoding |

## Verification
The bench sets STANDBY_CYCLES to 3 instead of the default 100. This makes the exact standby length countable in a few cycles, both after reset and after waking from sleep. The three sleep codes are set to the distinct values 8'h11, 8'h22 and 8'h33, so that a short, nominal or stretched code put in the wrong place shows up at once. The stretch option is left enabled, so both settings of the variability flag, and a flag change in the middle of a sleep, reach the sleep-code output.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

   // State encoding is visible on the state_out port.
   typedef enum logic [2:0] {
      ST_SLEEP    = 3'b000,
      ST_STANDBY  = 3'b001,
      ST_SAMPWAIT = 3'b010,
      ST_ACQUIRE  = 3'b011,
      ST_CIPHER   = 3'b100,
      ST_RADIO    = 3'b101
   } pstate_t;

   typedef logic [1:0] lpmode_t;

   localparam lpmode_t MODE_FULL      = 2'd0;
   localparam lpmode_t MODE_DIV_SHORT = 2'd1;
   localparam lpmode_t MODE_DIV_LONG  = 2'd2;
   localparam lpmode_t MODE_HALT      = 2'd3;

endpackage

// File: rtl/pwrseq_dwell.sv
// Counts the cycles spent in standby and flags the final one.
module pwrseq_dwell #(
   parameter int CYCLES = 100
) (
   input  logic clk,
   input  logic rst,
   input  logic active,
   output logic expire
);

   localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

   generate
      if (CYCLES == 1) begin : g_single
         assign expire = active;
      end else begin : g_count
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (rst || !active) begin
               cnt_q <= '0;
            end else if (!expire) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign expire = active && (cnt_q == CW'(CYCLES - 1));
      end
   endgenerate

endmodule

// File: rtl/pwrseq_core.sv
// State register, next-state choice, entry flag and sleep-length latch.
module pwrseq_core
   import pwrseq_pkg::*;
#(
   parameter bit STRETCH_EN = 1'b1
) (
   input  logic    clk,
   input  logic    rst,
   input  logic    dwell_done,
   input  logic    acq_done,
   input  logic    enc_done,
   input  logic    tx_done,
   input  logic    wake,
   input  logic    low_var,
   output pstate_t state_q,
   output logic    entered_q,
   output logic    stretch_q
);

   pstate_t state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_STANDBY:  if (dwell_done) state_d = ST_SAMPWAIT;
         ST_SAMPWAIT: if (wake)       state_d = ST_ACQUIRE;
         ST_ACQUIRE:  if (acq_done)   state_d = ST_CIPHER;
         ST_CIPHER:   if (enc_done)   state_d = ST_RADIO;
         ST_RADIO:    if (tx_done)    state_d = ST_SLEEP;
         ST_SLEEP:    if (wake)       state_d = ST_STANDBY;
         default:                     state_d = ST_STANDBY;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_STANDBY;
         entered_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         entered_q <= (state_d != state_q);
      end
   end

   generate
      if (STRETCH_EN) begin : g_stretch
         always_ff @(posedge clk) begin
            if (rst) begin
               stretch_q <= 1'b0;
            end else if (state_q == ST_RADIO && tx_done) begin
               stretch_q <= low_var;
            end
         end
      end else begin : g_fixed
         assign stretch_q = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/pwrseq_outmap.sv
// Maps the state to a mode request, sleep code and engine starts.
module pwrseq_outmap
   import pwrseq_pkg::*;
#(
   parameter int                CODE_W       = 8,
   parameter logic [CODE_W-1:0] SHORT_CODE   = 8'd25,
   parameter logic [CODE_W-1:0] NOMINAL_CODE = 8'd60,
   parameter logic [CODE_W-1:0] STRETCH_CODE = 8'd255
) (
   input  pstate_t           state_q,
   input  logic              entered_q,
   input  logic              stretch_q,
   output lpmode_t           mode_req,
   output logic [CODE_W-1:0] sleep_code,
   output logic              acq_start,
   output logic              enc_start,
   output logic              tx_start
);

   always_comb begin
      mode_req   = MODE_FULL;
      sleep_code = '0;
      case (state_q)
         ST_SAMPWAIT: begin
            mode_req   = MODE_HALT;
            sleep_code = SHORT_CODE;
         end
         ST_SLEEP: begin
            mode_req   = MODE_HALT;
            sleep_code = stretch_q ? STRETCH_CODE : NOMINAL_CODE;
         end
         ST_ACQUIRE: mode_req = MODE_DIV_SHORT;
         ST_RADIO:   mode_req = MODE_DIV_LONG;
         default:    mode_req = MODE_FULL;
      endcase
   end

   assign acq_start = entered_q && (state_q == ST_ACQUIRE);
   assign enc_start = entered_q && (state_q == ST_CIPHER);
   assign tx_start  = entered_q && (state_q == ST_RADIO);

endmodule

// File: rtl/sensor_pwr_seq.sv
module sensor_pwr_seq
   import pwrseq_pkg::*;
#(
   parameter int                STANDBY_CYCLES = 100,
   parameter int                CODE_W         = 8,
   parameter logic [CODE_W-1:0] SHORT_CODE     = 8'd25,
   parameter logic [CODE_W-1:0] NOMINAL_CODE   = 8'd60,
   parameter logic [CODE_W-1:0] STRETCH_CODE   = 8'd255,
   parameter bit                STRETCH_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              acq_done,
   input  logic              enc_done,
   input  logic              tx_done,
   input  logic              wake,
   input  logic              low_var,
   output logic [1:0]        mode_req,
   output logic [CODE_W-1:0] sleep_code,
   output logic              acq_start,
   output logic              enc_start,
   output logic              tx_start,
   output logic [2:0]        state_out
);

   generate
      if (STANDBY_CYCLES < 1) begin : g_bad_dwell
         $error("STANDBY_CYCLES must be at least 1");
      end
      if (CODE_W < 2) begin : g_bad_width
         $error("CODE_W must be at least 2");
      end
      if (SHORT_CODE == '0 || NOMINAL_CODE == '0 || STRETCH_CODE == '0) begin : g_bad_code
         $error("sleep codes must be nonzero");
      end
   endgenerate

   pstate_t state_q;
   logic    entered_q;
   logic    stretch_q;
   logic    dwell_done;
   lpmode_t mode_w;

   pwrseq_dwell #(
      .CYCLES (STANDBY_CYCLES)
   ) u_dwell (
      .clk    (clk),
      .rst    (rst),
      .active (state_q == ST_STANDBY),
      .expire (dwell_done)
   );

   pwrseq_core #(
      .STRETCH_EN (STRETCH_EN)
   ) u_core (
      .clk        (clk),
      .rst        (rst),
      .dwell_done (dwell_done),
      .acq_done   (acq_done),
      .enc_done   (enc_done),
      .tx_done    (tx_done),
      .wake       (wake),
      .low_var    (low_var),
      .state_q    (state_q),
      .entered_q  (entered_q),
      .stretch_q  (stretch_q)
   );

   pwrseq_outmap #(
      .CODE_W       (CODE_W),
      .SHORT_CODE   (SHORT_CODE),
      .NOMINAL_CODE (NOMINAL_CODE),
      .STRETCH_CODE (STRETCH_CODE)
   ) u_outmap (
      .state_q    (state_q),
      .entered_q  (entered_q),
      .stretch_q  (stretch_q),
      .mode_req   (mode_w),
      .sleep_code (sleep_code),
      .acq_start  (acq_start),
      .enc_start  (enc_start),
      .tx_start   (tx_start)
   );

   assign mode_req  = mode_w;
   assign state_out = state_q;

endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk
   import pwrseq_pkg::*;
#(
   parameter int                STANDBY_CYCLES = 100,
   parameter int                CODE_W         = 8,
   parameter logic [CODE_W-1:0] SHORT_CODE     = 8'd25
) (
   input logic              clk,
   input logic              rst,
   input logic              acq_done,
   input logic              enc_done,
   input logic              tx_done,
   input logic              wake,
   input logic [1:0]        mode_req,
   input logic [CODE_W-1:0] sleep_code,
   input logic              acq_start,
   input logic              enc_start,
   input logic              tx_start,
   input logic [2:0]        state_out
);

   localparam int SB_W = $clog2(STANDBY_CYCLES + 1) + 1;

   // Consecutive standby cycles seen before the current one.
   logic [SB_W-1:0] sb_run;

   always_ff @(posedge clk) begin
      if (rst || state_out != ST_STANDBY) begin
         sb_run <= '0;
      end else if (sb_run < SB_W'(STANDBY_CYCLES)) begin
         sb_run <= sb_run + 1'b1;
      end
   end

   p_reset_standby_r1: assert property (@(posedge clk)
      rst |=> (state_out == ST_STANDBY && mode_req == MODE_FULL
               && !acq_start && !enc_start && !tx_start && sleep_code == '0));

   p_standby_bound_r2: assert property (@(posedge clk) disable iff (rst)
      (state_out == ST_STANDBY) |-> (sb_run < SB_W'(STANDBY_CYCLES)));

   p_standby_exit_r2: assert property (@(posedge clk) disable iff (rst)
      (state_out == ST_STANDBY && sb_run == SB_W'(STANDBY_CYCLES - 1))
      |=> (state_out == ST_SAMPWAIT));

   p_wait_req_r3: assert property (@(posedge clk) disable iff (rst)
      (state_out == ST_SAMPWAIT) |-> (mode_req == MODE_HALT && sleep_code == SHORT_CODE));

   // Holds below also cover R9: foreign strobes leave the state unchanged.
   p_acq_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (state_out == ST_ACQUIRE && !acq_done) |=> (state_out == ST_ACQUIRE && !acq_start));

   p_start_single_r4: assert property (@(posedge clk) disable iff (rst)
      acq_start |=> !acq_start);

   p_cipher_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (state_out == ST_CIPHER && !enc_done) |=> (state_out == ST_CIPHER && !enc_start));

   p_cipher_mode_r5: assert property (@(posedge clk) disable iff (rst)
      (state_out == ST_CIPHER) |-> (mode_req == MODE_FULL));

   p_radio_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (state_out == ST_RADIO && !tx_done) |=> (state_out == ST_RADIO && mode_req == MODE_DIV_LONG));

   p_sleep_code_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (state_out == ST_SLEEP && !wake) |=> $stable(sleep_code));

   p_wake_resume_r8: assert property (@(posedge clk) disable iff (rst)
      (state_out == ST_SLEEP && wake) |=> (state_out == ST_STANDBY));

   p_idle_code_r10: assert property (@(posedge clk) disable iff (rst)
      (state_out != ST_SLEEP && state_out != ST_SAMPWAIT) |-> (sleep_code == '0));

   p_start_onehot_r11: assert property (@(posedge clk) disable iff (rst)
      $onehot0({acq_start, enc_start, tx_start}));

endmodule

bind sensor_pwr_seq pwrseq_chk #(
   .STANDBY_CYCLES (STANDBY_CYCLES),
   .CODE_W         (CODE_W),
   .SHORT_CODE     (SHORT_CODE)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .acq_done   (acq_done),
   .enc_done   (enc_done),
   .tx_done    (tx_done),
   .wake       (wake),
   .mode_req   (mode_req),
   .sleep_code (sleep_code),
   .acq_start  (acq_start),
   .enc_start  (enc_start),
   .tx_start   (tx_start),
   .state_out  (state_out)
);

// File: tb/sensor_pwr_seq_bench.sv
module sensor_pwr_seq_bench;

   localparam int         CLK_PERIOD = 10;
   localparam int         SB_LEN     = 3;
   localparam logic [7:0] SC         = 8'h11;
   localparam logic [7:0] NC         = 8'h22;
   localparam logic [7:0] XC         = 8'h33;

   localparam logic [2:0] S_SL = 3'b000;
   localparam logic [2:0] S_SB = 3'b001;
   localparam logic [2:0] S_WT = 3'b010;
   localparam logic [2:0] S_AQ = 3'b011;
   localparam logic [2:0] S_EN = 3'b100;
   localparam logic [2:0] S_TX = 3'b101;

   // {req[3:0], inputs {acq,enc,tx,wake,lowvar}, state, mode, code, starts {acq,enc,tx}}
   localparam int NV = 23;
   localparam logic [24:0] VEC [NV] = '{
      {4'd3,  5'b00000, S_WT, 2'd3, SC,    3'b000}, // R3 stays in sample-wait
      {4'd9,  5'b11100, S_WT, 2'd3, SC,    3'b000}, // R9 done strobes ignored
      {4'd4,  5'b00010, S_AQ, 2'd1, 8'h00, 3'b100}, // R4 wake -> acquire, start pulse
      {4'd4,  5'b00000, S_AQ, 2'd1, 8'h00, 3'b000}, // R4 pulse lasts one cycle
      {4'd9,  5'b01110, S_AQ, 2'd1, 8'h00, 3'b000}, // R9 wrong strobes in acquire
      {4'd5,  5'b10000, S_EN, 2'd0, 8'h00, 3'b010}, // R5 acquire done -> encrypt
      {4'd5,  5'b00000, S_EN, 2'd0, 8'h00, 3'b000}, // R5 hold
      {4'd9,  5'b10110, S_EN, 2'd0, 8'h00, 3'b000}, // R9 wrong strobes in encrypt
      {4'd6,  5'b01000, S_TX, 2'd2, 8'h00, 3'b001}, // R6 cipher done -> transmit
      {4'd6,  5'b00000, S_TX, 2'd2, 8'h00, 3'b000}, // R6 hold
      {4'd7,  5'b00100, S_SL, 2'd3, NC,    3'b000}, // R7 low flag -> nominal
      {4'd7,  5'b00001, S_SL, 2'd3, NC,    3'b000}, // R7 late flag change ignored
      {4'd9,  5'b11100, S_SL, 2'd3, NC,    3'b000}, // R9 done strobes in sleep
      {4'd8,  5'b00010, S_SB, 2'd0, 8'h00, 3'b000}, // R8 wake -> standby
      {4'd8,  5'b00000, S_SB, 2'd0, 8'h00, 3'b000}, // R8 standby restarted
      {4'd10, 5'b00000, S_SB, 2'd0, 8'h00, 3'b000}, // R10 no code in standby
      {4'd2,  5'b00000, S_WT, 2'd3, SC,    3'b000}, // R2 standby length after wake
      {4'd11, 5'b00010, S_AQ, 2'd1, 8'h00, 3'b100}, // R11 one start only
      {4'd4,  5'b10000, S_EN, 2'd0, 8'h00, 3'b010}, // R4 done in the entry cycle
      {4'd5,  5'b01000, S_TX, 2'd2, 8'h00, 3'b001}, // R5 done in the entry cycle
      {4'd7,  5'b00101, S_SL, 2'd3, XC,    3'b000}, // R7 high flag -> stretched
      {4'd7,  5'b00000, S_SL, 2'd3, XC,    3'b000}, // R7 held after flag drops
      {4'd8,  5'b00010, S_SB, 2'd0, 8'h00, 3'b000}  // R8 wake from stretched sleep
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       acq_done = 1'b0;
   logic       enc_done = 1'b0;
   logic       tx_done = 1'b0;
   logic       wake = 1'b0;
   logic       low_var = 1'b0;
   logic [1:0] mode_req;
   logic [7:0] sleep_code;
   logic       acq_start;
   logic       enc_start;
   logic       tx_start;
   logic [2:0] state_out;

   int  checks = 0;
   int  errors = 0;
   bit  finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   sensor_pwr_seq #(
      .STANDBY_CYCLES (SB_LEN),
      .CODE_W         (8),
      .SHORT_CODE     (SC),
      .NOMINAL_CODE   (NC),
      .STRETCH_CODE   (XC),
      .STRETCH_EN     (1'b1)
   ) u_sensor_pwr_seq (
      .clk        (clk),
      .rst        (rst),
      .acq_done   (acq_done),
      .enc_done   (enc_done),
      .tx_done    (tx_done),
      .wake       (wake),
      .low_var    (low_var),
      .mode_req   (mode_req),
      .sleep_code (sleep_code),
      .acq_start  (acq_start),
      .enc_start  (enc_start),
      .tx_start   (tx_start),
      .state_out  (state_out)
   );

   task automatic chk(input int req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic chk_all(input int req, input logic [2:0] st, input logic [1:0] md,
                          input logic [7:0] cd, input logic [2:0] go);
      chk(req, "state", 32'(state_out), 32'(st));
      chk(req, "mode", 32'(mode_req), 32'(md));
      chk(req, "sleep_code", 32'(sleep_code), 32'(cd));
      chk(req, "starts", 32'({acq_start, enc_start, tx_start}), 32'(go));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      chk_all(1, S_SB, 2'd0, 8'h00, 3'b000);      // R1 reset state
      rst = 1'b0;
      for (int k = 0; k < SB_LEN; k++) begin
         chk(2, "standby", 32'(state_out), 32'(S_SB)); // R2 standby length
         @(negedge clk);
      end
      chk_all(2, S_WT, 2'd3, SC, 3'b000);         // R2 then R3 sample-wait

      for (int i = 0; i < NV; i++) begin
         {acq_done, enc_done, tx_done, wake, low_var} = VEC[i][20:16];
         @(negedge clk);
         chk_all(int'(VEC[i][24:21]), VEC[i][15:13], VEC[i][12:11],
                 VEC[i][10:3], VEC[i][2:0]);
      end
      {acq_done, enc_done, tx_done, wake, low_var} = 5'b00000;

      // Standby from the last vector runs out into sample-wait.
      repeat (SB_LEN) @(negedge clk);
      chk(3, "state", 32'(state_out), 32'(S_WT));  // R3
      wake = 1'b1;
      @(negedge clk);
      wake = 1'b0;
      chk(4, "state", 32'(state_out), 32'(S_AQ));  // R4

      // R1: reset in the middle of acquisition
      rst = 1'b1;
      @(negedge clk);
      chk_all(1, S_SB, 2'd0, 8'h00, 3'b000);
      rst = 1'b0;

      // R9: wake during standby ignored; R2 length unchanged
      wake = 1'b1;
      for (int k = 0; k < SB_LEN; k++) begin
         chk(9, "standby", 32'(state_out), 32'(S_SB));
         @(negedge clk);
      end
      wake = 1'b0;
      chk_all(2, S_WT, 2'd3, SC, 3'b000);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule